// File: doc/BRIEF.md
# Quality-Gated Event Trigger With Tracked Baseline

This block sits on one channel of an environmental sensing node and watches a stream of compensated, signed fixed-point samples. Each sample arrives with four quality flags. From that stream the block decides when an event frame is worth sending. It runs two detectors. The first is a rate detector, which compares each sample with the one a fixed number of good samples earlier. The second is a level detector, which looks at how far the sample sits from a slowly learned baseline. The level detector uses separate enter and exit levels for the upward and downward directions, and a debounce count.

The baseline learns by a shifted fraction of the error, and each step is limited to a programmable cap. Learning stops whenever any quality flag is raised. A flagged sample also produces no event and wipes the short-term history of both detectors. After reset, nothing is reported until a learning period and then a settling period, both counted in good samples, have passed. Every decision is reported as a one-cycle pulse that carries a cause code and an entry/exit bit.

Top module: `qg_event_trigger`

## Requirements
- R1: After reset `run_ok` is 0 and no event is emitted. `run_ok` becomes 1 in the cycle after the good sample that completes `cfg_learn_n` learning samples followed by `cfg_settle_n` settling samples, and it then stays at 1. Flagged samples are not counted. A count of 0 behaves as 1.
- R2: The first good sample after reset loads `baseline` directly with its value.
- R3: Every later good sample adds clamp((sample − baseline) >>> `cfg_shift`, −`cfg_cap`, +`cfg_cap`) to `baseline`. The shift is arithmetic and rounds toward minus infinity, so `baseline` never moves by more than `cfg_cap` per sample.
- R4: A sample with any flag set leaves `baseline` unchanged. The flag bits are: bit 0 warm-up, bit 1 condensation, bit 2 contamination, bit 3 bus error.
- R5: The rate condition holds when the window already holds WIN_LEN earlier good samples and |sample − the good sample WIN_LEN positions back| > `cfg_rate_lim` (strictly greater). `rate_active` follows the condition on each good sample in run. Each change of `rate_active` emits event code 1.
- R6: From idle (`thr_state` 0), the state goes to high (`thr_state` 1) when sample − baseline > `cfg_rise_enter`. From high it returns to idle when sample − baseline < `cfg_rise_exit`. Both transitions emit code 2.
- R7: From idle, the state goes to low (`thr_state` 2) when sample − baseline < −`cfg_fall_enter`. From low it returns to idle when sample − baseline > −`cfg_fall_exit`. Both transitions emit code 3.
- R8: A level transition happens only after its condition has held on `cfg_debounce` consecutive good samples. A good sample that breaks the condition restarts the count. A setting of 0 acts as 1.
- R9: A flagged sample changes neither `thr_state` nor `rate_active` and emits no event. It empties the rate window and clears the debounce counts. While the window is not full, the rate condition is false.
- R10: When one sample would cause both a level transition and a change of `rate_active`, only the level transition is reported. `rate_active` is left unchanged and is evaluated again on the next good sample.
- R11: `evt_valid` pulses for exactly one cycle, in the cycle after the deciding sample. With it, `evt_code` gives the cause (1 rate, 2 upper level, 3 lower level) and `evt_enter` is 1 for an entry and 0 for an exit. When `evt_valid` is low, both fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | DATA_W | Signed compensated sample |
| s_flags | input | 4 | Quality flags: warm-up, condensation, contamination, bus error |
| cfg_rate_lim | input | DATA_W | Rate limit over the window |
| cfg_rise_enter | input | DATA_W | Upper entry level above baseline |
| cfg_rise_exit | input | DATA_W | Upper exit level above baseline |
| cfg_fall_enter | input | DATA_W | Lower entry distance below baseline |
| cfg_fall_exit | input | DATA_W | Lower exit distance below baseline |
| cfg_debounce | input | CNT_W | Consecutive samples needed for a level transition |
| cfg_shift | input | SHIFT_W | Baseline learning shift |
| cfg_cap | input | DATA_W | Largest baseline step per sample |
| cfg_learn_n | input | CNT_W | Learning samples after reset |
| cfg_settle_n | input | CNT_W | Settling samples after learning |
| evt_valid | output | 1 | Event pulse |
| evt_code | output | 2 | Event cause |
| evt_enter | output | 1 | 1 for entry, 0 for exit |
| thr_state | output | 2 | Level state: 0 idle, 1 high, 2 low |
| rate_active | output | 1 | Rate condition state |
| baseline | output | DATA_W | Tracked baseline |
| run_ok | output | 1 | Startup windows complete |

## Verification
If the baseline learns during a flagged sample, the error shows up on `baseline` in the very next cycle. It also shifts every later level decision. If the debounce counts or the rate history survive a flagged sample, the next one or two good samples bring an early transition on `thr_state` or `rate_active` and an extra pulse. Getting the priority between the two detectors wrong, or getting the window depth off by one, shows within one sample as a wrong `evt_code` or a pulse on the wrong sample. A broken startup count moves the rise of `run_ok`, and with it the first event, by whole samples.

// File: rtl/qg_pkg.sv
package qg_pkg;
   localparam int NFLAGS = 4;
   localparam int FLG_WARM = 0;
   localparam int FLG_COND = 1;
   localparam int FLG_CONT = 2;
   localparam int FLG_BUS  = 3;

   localparam logic [1:0] EC_NONE = 2'd0;
   localparam logic [1:0] EC_RATE = 2'd1;
   localparam logic [1:0] EC_RISE = 2'd2;
   localparam logic [1:0] EC_FALL = 2'd3;

   typedef enum logic [1:0] {TS_IDLE = 2'd0, TS_HIGH = 2'd1, TS_LOW = 2'd2} thr_state_t;
   typedef enum logic [1:0] {PH_LEARN = 2'd0, PH_SETTLE = 2'd1, PH_RUN = 2'd2} phase_t;
endpackage

// File: rtl/qg_startup_gate.sv
module qg_startup_gate #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             good,
   input  logic [CNT_W-1:0] learn_n,
   input  logic [CNT_W-1:0] settle_n,
   output logic             run
);
   import qg_pkg::*;

   phase_t         phase;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_nx;
   logic [CNT_W:0]   limit;

   assign cnt_nx = {1'b0, cnt} + 1'b1;
   assign limit  = (phase == PH_LEARN) ? {1'b0, learn_n} : {1'b0, settle_n};
   assign run    = (phase == PH_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_LEARN;
         cnt   <= '0;
      end else if (good && phase != PH_RUN) begin
         if (cnt_nx >= limit) begin
            cnt   <= '0;
            phase <= (phase == PH_LEARN) ? PH_SETTLE : PH_RUN;
         end else begin
            cnt <= cnt_nx[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/qg_baseline_track.sv
module qg_baseline_track #(
   parameter int DATA_W  = 16,
   parameter int SHIFT_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd,
   input  logic signed [DATA_W-1:0] sample,
   input  logic [SHIFT_W-1:0]       shift,
   input  logic [DATA_W-1:0]        cap,
   output logic signed [DATA_W-1:0] baseline,
   output logic signed [DATA_W:0]   diff
);
   localparam int DW = DATA_W + 1;

   logic                 seeded;
   logic signed [DW-1:0] step_raw;
   logic signed [DW-1:0] cap_s;
   logic signed [DW-1:0] step_cl;
   logic signed [DW-1:0] next_w;
   logic                 unused_msb;

   // the error is one bit wider than a sample so it never wraps
   assign diff     = $signed({sample[DATA_W-1], sample}) - $signed({baseline[DATA_W-1], baseline});
   assign step_raw = diff >>> shift;
   assign cap_s    = $signed({1'b0, cap});

   always_comb begin
      if (step_raw > cap_s)       step_cl = cap_s;
      else if (step_raw < -cap_s) step_cl = -cap_s;
      else                        step_cl = step_raw;
   end

   // the clamped step never exceeds |diff|, so the sum stays between baseline and sample
   assign next_w     = $signed({baseline[DATA_W-1], baseline}) + step_cl;
   assign unused_msb = next_w[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         baseline <= '0;
         seeded   <= 1'b0;
      end else if (upd) begin
         seeded   <= 1'b1;
         baseline <= seeded ? next_w[DATA_W-1:0] : sample;
      end
   end
endmodule

// File: rtl/qg_rate_window.sv
module qg_rate_window #(
   parameter int DATA_W  = 16,
   parameter int WIN_LEN = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     clear,
   input  logic                     eval,
   input  logic                     hold,
   input  logic signed [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0]        lim,
   output logic                     trans,
   output logic                     active
);
   localparam int FILL_W = $clog2(WIN_LEN + 1);
   localparam int DW     = DATA_W + 1;

   logic signed [DATA_W-1:0] win [WIN_LEN];
   logic [FILL_W-1:0]        fill;
   logic signed [DW-1:0]     delta;
   logic [DW-1:0]            mag;
   logic                     full;
   logic                     exceed;

   generate
      if (WIN_LEN < 1) begin : g_bad_len
         $error("qg_rate_window: WIN_LEN must be at least 1");
      end
      for (genvar i = 0; i < WIN_LEN; i++) begin : g_tap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win[i] <= '0;
            end else if (push && !clear) begin
               if (i == 0) win[i] <= sample;
               else        win[i] <= win[(i > 0) ? i - 1 : 0];
            end
         end
      end
   endgenerate

   assign full   = (fill == FILL_W'(WIN_LEN));
   assign delta  = $signed({sample[DATA_W-1], sample}) -
                   $signed({win[WIN_LEN-1][DATA_W-1], win[WIN_LEN-1]});
   assign mag    = delta[DW-1] ? DW'(-delta) : DW'(delta);
   assign exceed = full && (mag > {1'b0, lim});
   assign trans  = eval && !hold && (exceed != active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill   <= '0;
         active <= 1'b0;
      end else begin
         if (clear)               fill <= '0;
         else if (push && !full)  fill <= fill + 1'b1;
         if (trans)               active <= exceed;
      end
   end
endmodule

// File: rtl/qg_hyst_debounce.sv
module qg_hyst_debounce #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step,
   input  logic                   clear,
   input  logic signed [DATA_W:0] diff,
   input  logic [DATA_W-1:0]      rise_enter,
   input  logic [DATA_W-1:0]      rise_exit,
   input  logic [DATA_W-1:0]      fall_enter,
   input  logic [DATA_W-1:0]      fall_exit,
   input  logic [CNT_W-1:0]       deb,
   output logic [1:0]             state,
   output logic                   trans,
   output logic [1:0]             trans_code,
   output logic                   trans_enter
);
   import qg_pkg::*;

   localparam int EW = DATA_W + 2;

   thr_state_t         st, nxt;
   logic [CNT_W-1:0]   cnt_up, cnt_dn;
   logic [CNT_W:0]     up_nx, dn_nx, deb_eff;
   logic signed [EW-1:0] d_e, re_e, rx_e, fe_e, fx_e;
   logic               rise_in, rise_out, fall_in, fall_out;
   logic               cond_up, cond_dn, up_done, dn_done;

   assign d_e  = $signed({diff[DATA_W], diff});
   assign re_e = $signed({2'b00, rise_enter});
   assign rx_e = $signed({2'b00, rise_exit});
   assign fe_e = $signed({2'b00, fall_enter});
   assign fx_e = $signed({2'b00, fall_exit});

   assign rise_in  = d_e > re_e;
   assign rise_out = d_e < rx_e;
   assign fall_in  = d_e < -fe_e;
   assign fall_out = d_e > -fx_e;

   assign deb_eff = (deb == '0) ? (CNT_W+1)'(1) : {1'b0, deb};
   assign up_nx   = {1'b0, cnt_up} + 1'b1;
   assign dn_nx   = {1'b0, cnt_dn} + 1'b1;
   assign up_done = up_nx >= deb_eff;
   assign dn_done = dn_nx >= deb_eff;

   always_comb begin
      cond_up     = 1'b0;
      cond_dn     = 1'b0;
      nxt         = st;
      trans_code  = EC_NONE;
      trans_enter = 1'b0;
      case (st)
         TS_IDLE: begin
            cond_up = rise_in;
            cond_dn = fall_in;
            if (rise_in && up_done) begin
               nxt = TS_HIGH; trans_code = EC_RISE; trans_enter = 1'b1;
            end else if (fall_in && dn_done) begin
               nxt = TS_LOW;  trans_code = EC_FALL; trans_enter = 1'b1;
            end
         end
         TS_HIGH: begin
            cond_up = rise_out;
            if (rise_out && up_done) begin
               nxt = TS_IDLE; trans_code = EC_RISE;
            end
         end
         TS_LOW: begin
            cond_dn = fall_out;
            if (fall_out && dn_done) begin
               nxt = TS_IDLE; trans_code = EC_FALL;
            end
         end
         default: nxt = TS_IDLE;
      endcase
   end

   assign trans = step && (nxt != st);
   assign state = st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TS_IDLE;
         cnt_up <= '0;
         cnt_dn <= '0;
      end else if (clear) begin
         cnt_up <= '0;
         cnt_dn <= '0;
      end else if (step) begin
         if (trans) begin
            st     <= nxt;
            cnt_up <= '0;
            cnt_dn <= '0;
         end else begin
            cnt_up <= cond_up ? up_nx[CNT_W-1:0] : '0;
            cnt_dn <= cond_dn ? dn_nx[CNT_W-1:0] : '0;
         end
      end
   end
endmodule

// File: rtl/qg_event_trigger.sv
module qg_event_trigger #(
   parameter int DATA_W  = 16,
   parameter int WIN_LEN = 4,
   parameter int CNT_W   = 8,
   parameter int SHIFT_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s_valid,
   input  logic signed [DATA_W-1:0]  s_data,
   input  logic [qg_pkg::NFLAGS-1:0] s_flags,
   input  logic [DATA_W-1:0]         cfg_rate_lim,
   input  logic [DATA_W-1:0]         cfg_rise_enter,
   input  logic [DATA_W-1:0]         cfg_rise_exit,
   input  logic [DATA_W-1:0]         cfg_fall_enter,
   input  logic [DATA_W-1:0]         cfg_fall_exit,
   input  logic [CNT_W-1:0]          cfg_debounce,
   input  logic [SHIFT_W-1:0]        cfg_shift,
   input  logic [DATA_W-1:0]         cfg_cap,
   input  logic [CNT_W-1:0]          cfg_learn_n,
   input  logic [CNT_W-1:0]          cfg_settle_n,
   output logic                      evt_valid,
   output logic [1:0]                evt_code,
   output logic                      evt_enter,
   output logic [1:0]                thr_state,
   output logic                      rate_active,
   output logic signed [DATA_W-1:0]  baseline,
   output logic                      run_ok
);
   import qg_pkg::*;

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("qg_event_trigger: DATA_W must be at least 4");
      end
      if (SHIFT_W < 1 || (1 << SHIFT_W) > DATA_W + 1) begin : g_bad_shift
         $error("qg_event_trigger: SHIFT_W range exceeds the error width");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("qg_event_trigger: CNT_W must be at least 1");
      end
   endgenerate

   logic                   suspect, good, flagged, step;
   logic signed [DATA_W:0] diff;
   logic                   thr_trans, thr_enter, rate_trans;
   logic [1:0]             thr_code;

   assign suspect = |s_flags;
   assign good    = s_valid && !suspect;
   assign flagged = s_valid && suspect;
   assign step    = good && run_ok;

   qg_startup_gate #(.CNT_W(CNT_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .good     (good),
      .learn_n  (cfg_learn_n),
      .settle_n (cfg_settle_n),
      .run      (run_ok)
   );

   qg_baseline_track #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (good),
      .sample   (s_data),
      .shift    (cfg_shift),
      .cap      (cfg_cap),
      .baseline (baseline),
      .diff     (diff)
   );

   qg_hyst_debounce #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_hyst (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .clear       (flagged),
      .diff        (diff),
      .rise_enter  (cfg_rise_enter),
      .rise_exit   (cfg_rise_exit),
      .fall_enter  (cfg_fall_enter),
      .fall_exit   (cfg_fall_exit),
      .deb         (cfg_debounce),
      .state       (thr_state),
      .trans       (thr_trans),
      .trans_code  (thr_code),
      .trans_enter (thr_enter)
   );

   qg_rate_window #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (good),
      .clear  (flagged),
      .eval   (step),
      .hold   (thr_trans),
      .sample (s_data),
      .lim    (cfg_rate_lim),
      .trans  (rate_trans),
      .active (rate_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid <= 1'b0;
         evt_code  <= EC_NONE;
         evt_enter <= 1'b0;
      end else begin
         evt_valid <= thr_trans || rate_trans;
         if (thr_trans) begin
            evt_code  <= thr_code;
            evt_enter <= thr_enter;
         end else if (rate_trans) begin
            evt_code  <= EC_RATE;
            evt_enter <= !rate_active;
         end else begin
            evt_code  <= EC_NONE;
            evt_enter <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/qg_event_trigger_chk.sv
module qg_event_trigger_chk #(
   parameter int DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     s_valid,
   input logic [3:0]               s_flags,
   input logic [DATA_W-1:0]        cfg_cap,
   input logic                     evt_valid,
   input logic [1:0]               evt_code,
   input logic [1:0]               thr_state,
   input logic                     rate_active,
   input logic signed [DATA_W-1:0] baseline,
   input logic                     run_ok
);
   logic                     armed, ok_q, seen_ok, seen_q, rat_q;
   logic [1:0]               thr_q;
   logic signed [DATA_W-1:0] base_q;
   logic [DATA_W-1:0]        cap_q;
   logic signed [DATA_W:0]   move;
   logic [DATA_W:0]          move_mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0; ok_q <= 1'b0; seen_ok <= 1'b0; seen_q <= 1'b0;
         rat_q <= 1'b0; thr_q <= '0; base_q <= '0; cap_q <= '0;
      end else begin
         armed   <= 1'b1;
         ok_q    <= s_valid && (s_flags == 4'd0);
         seen_ok <= seen_ok || (s_valid && (s_flags == 4'd0));
         seen_q  <= seen_ok;
         rat_q   <= rate_active;
         thr_q   <= thr_state;
         base_q  <= baseline;
         cap_q   <= cfg_cap;
      end
   end

   assign move     = $signed({baseline[DATA_W-1], baseline}) - $signed({base_q[DATA_W-1], base_q});
   assign move_mag = move[DATA_W] ? -move : move;

   AST_NO_EVT_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> run_ok); // R1
   AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      run_ok |=> run_ok); // R1
   AST_BASE_SLEW: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ok_q && seen_q) |-> (move_mag <= {1'b0, cap_q})); // R3
   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !ok_q) |-> (baseline == base_q)); // R4
   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !ok_q) |-> (thr_state == thr_q && rate_active == rat_q && !evt_valid)); // R9
   AST_THR_CHANGE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && thr_state != thr_q) |-> (evt_valid && evt_code[1])); // R11
   AST_RATE_CHANGE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && rate_active != rat_q) |-> (evt_valid && evt_code == 2'd1)); // R5
   AST_EVT_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_code != 2'd0)); // R11
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      thr_state != 2'd3); // R6
endmodule

bind qg_event_trigger qg_event_trigger_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .s_valid     (s_valid),
   .s_flags     (s_flags),
   .cfg_cap     (cfg_cap),
   .evt_valid   (evt_valid),
   .evt_code    (evt_code),
   .thr_state   (thr_state),
   .rate_active (rate_active),
   .baseline    (baseline),
   .run_ok      (run_ok)
);

// File: tb/qg_event_trigger_bench.sv
`timescale 1ns/1ps
module qg_event_trigger_bench;
   localparam int DATA_W = 16;
   localparam int CNT_W  = 8;
   localparam int SHIFT_W = 4;

   typedef struct packed {
      logic [15:0] d;
      logic [3:0]  f;
      logic        ev;
      logic [1:0]  code;
      logic        ent;
      logic [1:0]  thr;
      logic        rat;
   } vec_t;

   // learn 2, settle 2, debounce 2, cap 0, window 4, rate limit 50,
   // rise 40/20, fall 30/10; baseline seeded to 100 by the first row
   localparam vec_t VEC [24] = '{
      '{16'd100, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R2 seed
      '{16'd100, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd100, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd100, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd100, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // first run sample
      '{16'd150, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R8 count 1; R5 rate equal to limit
      '{16'd150, 4'h0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b0}, // R6 enter high
      '{16'd151, 4'h0, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1}, // R5 rate enter
      '{16'd151, 4'h0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b1},
      '{16'd151, 4'h0, 1'b1, 2'd1, 1'b0, 2'd1, 1'b0}, // R5 rate exit
      '{16'd110, 4'h0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0},
      '{16'd130, 4'h0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0}, // R8 restart
      '{16'd110, 4'h0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0},
      '{16'd110, 4'h0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0}, // R6 exit high
      '{16'd60,  4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd60,  4'h0, 1'b1, 2'd3, 1'b1, 2'd2, 1'b0}, // R7 enter low; R10 rate held
      '{16'd55,  4'h0, 1'b1, 2'd1, 1'b1, 2'd2, 1'b1}, // R10 deferred rate entry
      '{16'd500, 4'h1, 1'b0, 2'd0, 1'b0, 2'd2, 1'b1}, // R9 warm-up flag
      '{16'd95,  4'h0, 1'b1, 2'd1, 1'b0, 2'd2, 1'b0}, // R9 empty window exits rate
      '{16'd95,  4'h0, 1'b1, 2'd3, 1'b0, 2'd0, 1'b0}, // R7 exit low
      '{16'd150, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd150, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R9 bus error clears count
      '{16'd150, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0},
      '{16'd150, 4'h0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b0}  // R8 full count again
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_valid = 1'b0;
   logic signed [DATA_W-1:0] s_data = '0;
   logic [3:0] s_flags = '0;
   logic [DATA_W-1:0] cfg_rate_lim = '0, cfg_rise_enter = '0, cfg_rise_exit = '0;
   logic [DATA_W-1:0] cfg_fall_enter = '0, cfg_fall_exit = '0, cfg_cap = '0;
   logic [CNT_W-1:0]  cfg_debounce = '0, cfg_learn_n = '0, cfg_settle_n = '0;
   logic [SHIFT_W-1:0] cfg_shift = '0;
   logic evt_valid, evt_enter, rate_active, run_ok;
   logic [1:0] evt_code, thr_state;
   logic signed [DATA_W-1:0] baseline;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   qg_event_trigger u_qg_event_trigger (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_flags(s_flags),
      .cfg_rate_lim(cfg_rate_lim), .cfg_rise_enter(cfg_rise_enter), .cfg_rise_exit(cfg_rise_exit),
      .cfg_fall_enter(cfg_fall_enter), .cfg_fall_exit(cfg_fall_exit), .cfg_debounce(cfg_debounce),
      .cfg_shift(cfg_shift), .cfg_cap(cfg_cap), .cfg_learn_n(cfg_learn_n), .cfg_settle_n(cfg_settle_n),
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_enter(evt_enter), .thr_state(thr_state),
      .rate_active(rate_active), .baseline(baseline), .run_ok(run_ok)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive one sample; return at the negedge after the consuming edge
   task automatic put(input logic signed [DATA_W-1:0] d, input logic [3:0] f);
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_flags = f;
      @(negedge clk);
      s_valid = 1'b0; s_flags = '0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   initial begin
      cfg_learn_n = 8'd2; cfg_settle_n = 8'd2; cfg_debounce = 8'd2;
      cfg_shift = 4'd2; cfg_cap = 16'd0; cfg_rate_lim = 16'd50;
      cfg_rise_enter = 16'd40; cfg_rise_exit = 16'd20;
      cfg_fall_enter = 16'd30; cfg_fall_exit = 16'd10;
      do_reset();

      // reset state
      check("R1", "run_ok at reset", int'(run_ok), 0);
      check("R11", "evt_valid at reset", int'(evt_valid), 0);
      check("R6", "thr_state at reset", int'(thr_state), 0);
      check("R5", "rate_active at reset", int'(rate_active), 0);
      check("R2", "baseline at reset", int'(baseline), 0);

      for (int i = 0; i < 24; i++) begin
         put($signed(VEC[i].d), VEC[i].f);
         check("R11", $sformatf("row %0d evt_valid", i), int'(evt_valid), int'(VEC[i].ev));
         check("R11", $sformatf("row %0d evt_code", i), int'(evt_code), int'(VEC[i].code));
         check("R11", $sformatf("row %0d evt_enter", i), int'(evt_enter), int'(VEC[i].ent));
         check("R6", $sformatf("row %0d thr_state", i), int'(thr_state), int'(VEC[i].thr));
         check("R5", $sformatf("row %0d rate_active", i), int'(rate_active), int'(VEC[i].rat));
      end
      check("R2", "baseline after seed with zero cap", int'(baseline), 100);

      // baseline learning and slew cap
      cfg_learn_n = 8'd1; cfg_settle_n = 8'd1; cfg_shift = 4'd2; cfg_cap = 16'd8;
      cfg_rise_enter = 16'd10000; cfg_fall_enter = 16'd10000; cfg_rate_lim = 16'hFFFF;
      do_reset();
      put(16'sd1000, 4'h0); check("R2", "seed", int'(baseline), 1000);
      put(16'sd1100, 4'h0); check("R3", "capped rise", int'(baseline), 1008);
      put(16'sd1016, 4'h0); check("R3", "shifted step", int'(baseline), 1010);
      put(16'sd900,  4'h0); check("R3", "capped fall", int'(baseline), 1002);
      put(16'sd1001, 4'h0); check("R3", "floor rounding", int'(baseline), 1001);
      for (int b = 0; b < 4; b++) begin
         put(16'sd2000, 4'(1 << b));
         check("R4", $sformatf("frozen on flag bit %0d", b), int'(baseline), 1001);
      end

      // startup windows, flagged samples not counted, debounce 0 acts as 1
      cfg_learn_n = 8'd3; cfg_settle_n = 8'd2; cfg_cap = 16'd0; cfg_debounce = 8'd0;
      cfg_rise_enter = 16'd10; cfg_rise_exit = 16'd5;
      do_reset();
      put(16'sd0, 4'h0);   check("R1", "run_ok learn 1", int'(run_ok), 0);
      put(16'sd100, 4'h0); check("R1", "run_ok learn 2", int'(run_ok), 0);
      check("R1", "no event in learning", int'(evt_valid), 0);
      put(16'sd100, 4'h2); check("R1", "flagged not counted", int'(run_ok), 0);
      put(16'sd100, 4'h0); check("R1", "run_ok learn 3", int'(run_ok), 0);
      put(16'sd100, 4'h0); check("R1", "run_ok settle 1", int'(run_ok), 0);
      check("R1", "no event in settling", int'(evt_valid), 0);
      put(16'sd100, 4'h0); check("R1", "run_ok after settle", int'(run_ok), 1);
      check("R1", "no event on completing sample", int'(evt_valid), 0);
      put(16'sd100, 4'h0);
      check("R8", "debounce 0 immediate event", int'(evt_valid), 1);
      check("R6", "code rise", int'(evt_code), 2);
      @(negedge clk);
      check("R11", "pulse lasts one cycle", int'(evt_valid), 0);
      check("R11", "code cleared", int'(evt_code), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule